// File: doc/BRIEF.md
# Keyboard Latch with Key-Available Strobe

This block holds the most recent key code that a keyboard front end delivers, and it exposes that code on a simple synchronous memory-mapped bus. A one-cycle key-valid pulse loads a 7-bit code with bit 7 forced high. Bit 7 acts as the key-available flag. The code is written into two mirrored byte registers: a data register and a strobe register. Software polls the data address until bit 7 is set. It then touches the strobe-clear address, which drops bit 7 in both registers and keeps the low seven bits.

The block also reports three push-button inputs at three consecutive read addresses. The bus side is combinational. For every access the block decodes, it returns read data and a hit flag in the same cycle. The surrounding memory system serves an access only when hit is low. All register updates take effect at the next rising clock edge.

Top module: `kbd_latch`

## Requirements
- R1: After reset, both the data register and the strobe register hold 0x00, so a read of the data address (0xC000) returns 0x00.
- R2: A key-valid pulse with code k loads 0x80 | k into both registers at the next clock edge.
- R3: A read of the data address returns the data register as it is and does not change either register.
- R4: A read of the strobe-clear address (0xC010) returns the strobe register as it was before the access. At the next edge, bit 7 of both registers is cleared and bits 6:0 are kept.
- R5: A write to the strobe-clear address clears bit 7 of both registers, exactly as a read does.
- R6: When a key-valid pulse arrives in the same cycle as a strobe-clear access, the key load wins and bit 7 stays set.
- R7: A read of button address 0xC061 + i (i = 0, 1, 2) returns button i in bit 7, with bits 6:0 zero.
- R8: Hit is high for a read of 0xC000, a read of 0xC061 to 0xC063, and a read or write of 0xC010. Hit is low for every other access and for idle cycles, and read data is 0x00 whenever hit is low.
- R9: A write to the data address or to a button address is not claimed (hit low) and changes neither register.
- R10: The data and strobe registers always hold the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| bus_hit | output | 1 | The access is served by this block |
| key_valid | input | 1 | One-cycle pulse: a new key code is present |
| key_code | input | 7 | Key code that key_valid qualifies |
| btn | input | 3 | Push-button levels, bit i is button i |

## Verification
Read data and hit are combinational, so they are due in the same cycle as the access. The bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. Register effects from a key pulse or a strobe clear are due one edge later. The bench's reference model changes its own copy only at the rising edge, so the first read in the following cycle checks the new value. Collisions and unclaimed writes are checked the same way: a read in the next cycle must show the expected byte.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = BYTE_W - 1;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [BYTE_W-1:0] strb;
    } kbd_state_t;
endpackage

// File: rtl/kbd_decode.sv
module kbd_decode #(
    parameter int                ADDR_W   = 16,
    parameter int                NUM_BTN  = 3,
    parameter logic [ADDR_W-1:0] DATA_ADR = 16'hC000,
    parameter logic [ADDR_W-1:0] CLR_ADR  = 16'hC010,
    parameter logic [ADDR_W-1:0] BTN_ADR  = 16'hC061
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd,
    input  logic               wr,
    output logic               rd_data,
    output logic               clr_evt,
    output logic [NUM_BTN-1:0] rd_btn
);
    assign rd_data = rd && (addr == DATA_ADR);
    assign clr_evt = (rd || wr) && (addr == CLR_ADR);

    for (genvar i = 0; i < NUM_BTN; i++) begin : g_btn
        localparam logic [ADDR_W-1:0] ThisAdr = ADDR_W'(BTN_ADR + i);
        assign rd_btn[i] = rd && (addr == ThisAdr);
    end
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
    import kbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_valid,
    input  logic [CODE_W-1:0] key_code,
    input  logic              clr_evt,
    output logic [BYTE_W-1:0] data_q,
    output logic [BYTE_W-1:0] strb_q
);
    kbd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_evt) begin
            st_d.data[BYTE_W-1] = 1'b0;
            st_d.strb[BYTE_W-1] = 1'b0;
        end
        if (key_valid) begin
            st_d.data = {1'b1, key_code};
            st_d.strb = {1'b1, key_code};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_q = st_q.data;
    assign strb_q = st_q.strb;
endmodule

// File: rtl/kbd_rdmux.sv
module kbd_rdmux
    import kbd_pkg::*;
#(
    parameter int NUM_BTN = 3
) (
    input  logic               rd,
    input  logic               rd_data,
    input  logic               clr_evt,
    input  logic [NUM_BTN-1:0] rd_btn,
    input  logic [BYTE_W-1:0]  data_q,
    input  logic [BYTE_W-1:0]  strb_q,
    input  logic [NUM_BTN-1:0] btn,
    output logic [BYTE_W-1:0]  rdata,
    output logic               hit
);
    logic [NUM_BTN-1:0] btn_bit;

    for (genvar i = 0; i < NUM_BTN; i++) begin : g_bsel
        assign btn_bit[i] = rd_btn[i] & btn[i];
    end

    always_comb begin
        rdata = '0;
        if (rd_data) begin
            rdata = data_q;
        end else if (clr_evt && rd) begin
            rdata = strb_q;
        end else if (|rd_btn) begin
            rdata = {|btn_bit, {(BYTE_W-1){1'b0}}};
        end
    end

    assign hit = rd_data || clr_evt || (|rd_btn);
endmodule

// File: rtl/kbd_latch.sv
module kbd_latch
    import kbd_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                NUM_BTN  = 3,
    parameter logic [ADDR_W-1:0] DATA_ADR = 16'hC000,
    parameter logic [ADDR_W-1:0] CLR_ADR  = 16'hC010,
    parameter logic [ADDR_W-1:0] BTN_ADR  = 16'hC061
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    output logic [BYTE_W-1:0]  bus_rdata,
    output logic               bus_hit,
    input  logic               key_valid,
    input  logic [CODE_W-1:0]  key_code,
    input  logic [NUM_BTN-1:0] btn
);
    logic               rd_data;
    logic               clr_evt;
    logic [NUM_BTN-1:0] rd_btn;
    logic [BYTE_W-1:0]  kbd_data;
    logic [BYTE_W-1:0]  kbd_strb;

    kbd_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_BTN (NUM_BTN),
        .DATA_ADR(DATA_ADR),
        .CLR_ADR (CLR_ADR),
        .BTN_ADR (BTN_ADR)
    ) u_dec (
        .addr   (bus_addr),
        .rd     (bus_rd),
        .wr     (bus_wr),
        .rd_data(rd_data),
        .clr_evt(clr_evt),
        .rd_btn (rd_btn)
    );

    kbd_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_valid(key_valid),
        .key_code (key_code),
        .clr_evt  (clr_evt),
        .data_q   (kbd_data),
        .strb_q   (kbd_strb)
    );

    kbd_rdmux #(
        .NUM_BTN(NUM_BTN)
    ) u_mux (
        .rd     (bus_rd),
        .rd_data(rd_data),
        .clr_evt(clr_evt),
        .rd_btn (rd_btn),
        .data_q (kbd_data),
        .strb_q (kbd_strb),
        .btn    (btn),
        .rdata  (bus_rdata),
        .hit    (bus_hit)
    );
endmodule

// File: rtl/kbd_latch_chk.sv
module kbd_latch_chk #(
    parameter int                ADDR_W   = 16,
    parameter int                NUM_BTN  = 3,
    parameter logic [ADDR_W-1:0] CLR_ADR  = 16'hC010,
    parameter logic [ADDR_W-1:0] BTN_ADR  = 16'hC061
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [7:0]         bus_rdata,
    input logic               bus_hit,
    input logic               key_valid,
    input logic [6:0]         key_code,
    input logic [NUM_BTN-1:0] btn,
    input logic [7:0]         kbd_data,
    input logic [7:0]         kbd_strb
);
    logic clr_acc;
    assign clr_acc = (bus_rd || bus_wr) && (bus_addr == CLR_ADR);

    assert_key_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> kbd_data == {1'b1, $past(key_code)});

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_valid && !clr_acc) |=> $stable(kbd_data));

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_acc && !key_valid) |=>
            (kbd_strb[7] == 1'b0) && (kbd_strb[6:0] == $past(kbd_strb[6:0])));

    assert_collide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_acc && key_valid) |=> kbd_strb[7]);

    assert_btn0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == BTN_ADR) |-> bus_rdata == {btn[0], 7'b0});

    assert_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_hit |-> bus_rdata == 8'h00);

    assert_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_data == kbd_strb);
endmodule

bind kbd_latch kbd_latch_chk #(
    .ADDR_W (ADDR_W),
    .NUM_BTN(NUM_BTN),
    .CLR_ADR(CLR_ADR),
    .BTN_ADR(BTN_ADR)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_rdata(bus_rdata),
    .bus_hit  (bus_hit),
    .key_valid(key_valid),
    .key_code (key_code),
    .btn      (btn),
    .kbd_data (kbd_data),
    .kbd_strb (kbd_strb)
);

// File: tb/kbd_latch_bench.sv
`timescale 1ns/1ps
module kbd_latch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        bus_hit;
    logic        key_valid = 1'b0;
    logic [6:0]  key_code = '0;
    logic [2:0]  btn = '0;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    int m_data = 0;
    int m_strb = 0;

    always #10 clk = ~clk;

    kbd_latch u_kbd_latch (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_rdata(bus_rdata), .bus_hit(bus_hit),
        .key_valid(key_valid), .key_code(key_code), .btn(btn)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung run, expected end before 5000 cycles");
            finish_run();
        end
    end

    task automatic step(input logic [15:0] a, input logic rd, input logic wr,
                        input logic kv, input logic [6:0] code,
                        input logic [2:0] b, input string req);
        int exp_rd;
        bit exp_hit;
        bus_addr = a; bus_rd = rd; bus_wr = wr;
        key_valid = kv; key_code = code; btn = b;
        #1;
        exp_hit = (rd && (a == 16'hC000 || (a >= 16'hC061 && a <= 16'hC063)))
                  || ((rd || wr) && a == 16'hC010);
        exp_rd = 0;
        if (rd && a == 16'hC000) exp_rd = m_data;
        else if (rd && a == 16'hC010) exp_rd = m_strb;
        else if (rd && a >= 16'hC061 && a <= 16'hC063)
            exp_rd = b[a - 16'hC061] ? 8'h80 : 8'h00;
        tests++;
        if (bus_hit !== exp_hit || bus_rdata !== 8'(exp_rd)) begin
            fails++;
            $display("FAIL %s addr=%h: actual hit=%0b data=%h, expected hit=%0b data=%h",
                     req, a, bus_hit, bus_rdata, exp_hit, 8'(exp_rd));
        end
        @(posedge clk);
        if ((rd || wr) && a == 16'hC010) begin
            m_data = m_data & 8'h7f;
            m_strb = m_strb & 8'h7f;
        end
        if (kv) begin
            m_data = 8'h80 | code;
            m_strb = 8'h80 | code;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state visible at both mirrored addresses
        step(16'hC000, 1, 0, 0, 7'h00, 3'b000, "R1");
        step(16'hC010, 1, 0, 0, 7'h00, 3'b000, "R1");
        // R2: key load, then data read shows strobe set
        step(16'h0000, 0, 0, 1, 7'h41, 3'b000, "R2");
        step(16'hC000, 1, 0, 0, 7'h00, 3'b000, "R2");
        // R3: repeated data reads do not clear
        step(16'hC000, 1, 0, 0, 7'h00, 3'b000, "R3");
        step(16'hC000, 1, 0, 0, 7'h00, 3'b000, "R3");
        // R4: clear read returns old byte, then bit 7 gone, low bits kept
        step(16'hC010, 1, 0, 0, 7'h00, 3'b000, "R4");
        step(16'hC000, 1, 0, 0, 7'h00, 3'b000, "R4");
        step(16'hC010, 1, 0, 0, 7'h00, 3'b000, "R4");
        // R5: write to clear address clears too
        step(16'h0000, 0, 0, 1, 7'h7f, 3'b000, "R5");
        step(16'hC010, 0, 1, 0, 7'h00, 3'b000, "R5");
        step(16'hC000, 1, 0, 0, 7'h00, 3'b000, "R5");
        // R6: key pulse and clear in one cycle: key wins
        step(16'hC010, 1, 0, 1, 7'h2a, 3'b000, "R6");
        step(16'hC000, 1, 0, 0, 7'h00, 3'b000, "R6");
        step(16'hC010, 0, 1, 1, 7'h05, 3'b000, "R6");
        step(16'hC000, 1, 0, 0, 7'h00, 3'b000, "R6");
        // R7: push buttons, several patterns
        for (int p = 0; p < 8; p++) begin
            for (int i = 0; i < 3; i++)
                step(16'hC061 + 16'(i), 1, 0, 0, 7'h00, 3'(p), "R7");
        end
        // R8: unmapped reads, idle cycle, neighbour addresses
        step(16'hC011, 1, 0, 0, 7'h00, 3'b111, "R8");
        step(16'hC060, 1, 0, 0, 7'h00, 3'b111, "R8");
        step(16'hC064, 1, 0, 0, 7'h00, 3'b111, "R8");
        step(16'hC000, 0, 0, 0, 7'h00, 3'b111, "R8");
        step(16'h1234, 0, 1, 0, 7'h00, 3'b111, "R8");
        // R9: writes to data and button addresses unclaimed, no effect
        step(16'hC000, 0, 1, 0, 7'h00, 3'b000, "R9");
        step(16'hC062, 0, 1, 0, 7'h00, 3'b010, "R9");
        step(16'hC000, 1, 0, 0, 7'h00, 3'b000, "R9");
        // R10: mirrored registers after a new key
        step(16'h0000, 0, 0, 1, 7'h13, 3'b000, "R10");
        step(16'hC000, 1, 0, 0, 7'h00, 3'b000, "R10");
        step(16'hC010, 1, 0, 0, 7'h00, 3'b000, "R10");
        step(16'hC010, 1, 0, 0, 7'h00, 3'b000, "R10");
        // R1: reset in the middle clears a loaded key
        step(16'h0000, 0, 0, 1, 7'h66, 3'b000, "R2");
        rst_n = 1'b0;
        m_data = 0;
        m_strb = 0;
        @(negedge clk);
        rst_n = 1'b1;
        step(16'hC000, 1, 0, 0, 7'h00, 3'b000, "R1");
        finish_run();
    end
endmodule